// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block connects a synchronous request/acknowledge port to an asynchronous static RAM of 32K words by 8 bits. It drives the memory's address and its three active-low strobes: chip select, output enable and write enable. The 8-bit data bus is split into an outgoing value, a driver enable and an incoming value, so that the tristate buffer can sit at the chip pads. Each access runs as a fixed sequence of clock cycles. The length of every phase comes from a timing minimum given in nanoseconds. That minimum is divided by the clock period and rounded up, and any nonzero minimum takes at least one cycle.

A write holds chip select and write enable low together for a computed window. The controller keeps its own data drivers off for the first part of that window, so that the memory's outputs have time to release. It then drives the data until the edge that raises write enable. A read lowers chip select and output enable together while write enable stays high. The returned byte is sampled on the last cycle of the access window. Every access ends with all strobes high and a single-cycle acknowledge.

While the controller is idle it can be placed in a low-power retention state. In that state chip select is held high. When the supply is restored, a recovery lockout of a programmable length runs. New requests are held off, and a busy flag is raised, from retention entry until the lockout has run out.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, memCsN, memWeN and memOeN are 1, memDqOe, ackValid and busy are 0, and reqReady is 1.
- R2: memWeN is low only while memCsN is low and memOeN is high. Each write keeps memWeN low for max(ceil(T_WP), ceil(T_WHZ)+ceil(T_DW)) cycles and stores reqWdata at reqAddr on the rising edge of memWeN.
- R3: memAddr does not change on any cycle in which memCsN stays low from the previous cycle.
- R4: memDqOe is 1 only while memWeN is low. It rises after ceil(T_WHZ) cycles of memWeN low, stays set until the edge that raises memWeN, and lasts at least ceil(T_DW) cycles. The controller never drives the bus while the memory is driving it.
- R5: A read holds memCsN and memOeN low, with memWeN high, for max(ceil(T_AA), ceil(T_OE)) cycles. It returns the value present on memDqIn in the last of those cycles on ackRdata.
- R6: ackValid is a one-cycle pulse, and all three strobes are high in that cycle. Counted in rising edges after the accepting edge, it appears after the strobe window plus max(1, ceil(T_WC or T_RC) minus the window) minus 1: 6 edges for a write and 7 for a read at the default timing with a 10 ns clock.
- R7: retReq is accepted only in the idle state and takes priority over a request in the same cycle. From the next cycle busy is 1, reqReady is 0 and memCsN stays 1, and pending requests are not started.
- R8: After retExit is sampled in retention, busy stays 1 and reqReady stays 0 for ceil(T_REC) cycles. After that a held request is accepted.
- R9: retReq asserted while an access is in progress has no effect. The access completes and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Access request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Word address |
| reqWdata | input | DATA_W | Write data |
| reqReady | output | 1 | Request accepted on this edge when high |
| ackValid | output | 1 | One-cycle completion pulse |
| ackRdata | output | DATA_W | Read data, valid with ackValid |
| retReq | input | 1 | Enter retention (honoured when idle) |
| retExit | input | 1 | Supply restored; start recovery lockout |
| busy | output | 1 | Retention or recovery in progress |
| memAddr | output | ADDR_W | Memory address |
| memCsN | output | 1 | Chip select, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memDqOut | output | DATA_W | Data toward the memory |
| memDqOe | output | 1 | Enable for the data drivers |
| memDqIn | input | DATA_W | Data from the memory |

## Verification
The bench counts the rising edges that follow the accepting edge and samples ackValid at each falling edge. The ack is due 6 edges later for a write and 7 for a read. After retExit, reqReady is due exactly 100 edges later with a 1000 ns lockout. All of these counts are worked out in the bench from the nanosecond figures. A cycle-level memory model samples the strobes on falling edges. It measures the write-enable low time, the time before the controller drives the bus and the time the controller drives it, each against its nanosecond minimum. It returns a wrong byte until 70 ns of read access have passed, so a capture made one cycle early shows up as a data mismatch on the ack.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WR, ST_WEND, ST_RD, ST_REND, ST_RET, ST_RECOV
  } ctrlState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;     // latch request address and data
    logic capture;  // sample memory data bus
    logic drive;    // enable write-data drivers
  } dpStrobe_t;

  // Nanoseconds to whole cycles, rounded up; zero stays zero
  function automatic int cycFromNs(input int ns, input int clkNs);
    return (ns <= 0) ? 0 : (ns + clkNs - 1) / clkNs;
  endfunction

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctrl_fsm.sv
module sram_ctrl_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int CLK_NS   = 10,
  parameter int T_WP_NS  = 55,
  parameter int T_DW_NS  = 30,
  parameter int T_WHZ_NS = 30,
  parameter int T_WC_NS  = 70,
  parameter int T_AA_NS  = 70,
  parameter int T_OE_NS  = 35,
  parameter int T_RC_NS  = 70,
  parameter int T_REC_NS = 5000000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqWrite,
  input  logic      retReq,
  input  logic      retExit,
  output logic      reqReady,
  output logic      ackValid,
  output logic      busy,
  output logic      csN,
  output logic      weN,
  output logic      oeN,
  output dpStrobe_t strobe
);

  localparam int WHZ_C    = cycFromNs(T_WHZ_NS, CLK_NS);
  localparam int DW_C     = maxOf(1, cycFromNs(T_DW_NS, CLK_NS));
  localparam int WE_LOW_C = maxOf(cycFromNs(T_WP_NS, CLK_NS), WHZ_C + DW_C);
  localparam int DRV_C    = WE_LOW_C - WHZ_C;
  localparam int WTAIL_C  = maxOf(1, cycFromNs(T_WC_NS, CLK_NS) - WE_LOW_C);
  localparam int RD_C     = maxOf(1, maxOf(cycFromNs(T_AA_NS, CLK_NS),
                                           cycFromNs(T_OE_NS, CLK_NS)));
  localparam int RTAIL_C  = maxOf(1, cycFromNs(T_RC_NS, CLK_NS) - RD_C);
  localparam int REC_C    = maxOf(1, cycFromNs(T_REC_NS, CLK_NS));
  localparam int MAX_C    = maxOf(maxOf(WE_LOW_C, WTAIL_C),
                                  maxOf(maxOf(RD_C, RTAIL_C), REC_C));
  localparam int CNT_W    = $clog2(MAX_C + 1);

  ctrlState_e       state;
  logic [CNT_W-1:0] cnt;
  logic             cntDone;
  logic             accept;

  assign cntDone = (cnt == '0);
  assign reqReady = (state == ST_IDLE) && !retReq;
  assign accept   = reqReady && reqValid;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (retReq) begin
            state <= ST_RET;
          end else if (reqValid) begin
            state <= reqWrite ? ST_WR : ST_RD;
            cnt   <= reqWrite ? CNT_W'(WE_LOW_C - 1) : CNT_W'(RD_C - 1);
          end
        end
        ST_WR: begin
          if (cntDone) begin
            state <= ST_WEND;
            cnt   <= CNT_W'(WTAIL_C - 1);
          end else cnt <= cnt - 1'b1;
        end
        ST_RD: begin
          if (cntDone) begin
            state <= ST_REND;
            cnt   <= CNT_W'(RTAIL_C - 1);
          end else cnt <= cnt - 1'b1;
        end
        ST_WEND, ST_REND, ST_RECOV: begin
          if (cntDone) state <= ST_IDLE;
          else cnt <= cnt - 1'b1;
        end
        ST_RET: begin
          if (retExit) begin
            state <= ST_RECOV;
            cnt   <= CNT_W'(REC_C - 1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    csN      = !((state == ST_WR) || (state == ST_RD));
    weN      = (state != ST_WR);
    oeN      = (state != ST_RD);
    ackValid = ((state == ST_WEND) || (state == ST_REND)) && cntDone;
    busy     = (state == ST_RET) || (state == ST_RECOV);
    strobe.load    = accept;
    strobe.capture = (state == ST_RD) && cntDone;
    strobe.drive   = (state == ST_WR) && (cnt < CNT_W'(DRV_C));
  end

endmodule

// File: rtl/sram_ctrl_dp.sv
module sram_ctrl_dp
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W = 15,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDqIn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  output logic [DATA_W-1:0] ackRdata
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdataQ;

  // Address and write data change only on acceptance, when chip select is high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (strobe.load) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdataQ <= '0;
    else if (strobe.capture) rdataQ <= memDqIn;
  end

  assign memAddr  = addrQ;
  assign memDqOut = wdataQ;
  assign memDqOe  = strobe.drive;
  assign ackRdata = rdataQ;

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W   = 15,
  parameter int DATA_W   = 8,
  parameter int CLK_NS   = 10,
  parameter int T_WP_NS  = 55,
  parameter int T_DW_NS  = 30,
  parameter int T_WHZ_NS = 30,
  parameter int T_WC_NS  = 70,
  parameter int T_AA_NS  = 70,
  parameter int T_OE_NS  = 35,
  parameter int T_RC_NS  = 70,
  parameter int T_REC_NS = 5000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  output logic              ackValid,
  output logic [DATA_W-1:0] ackRdata,
  input  logic              retReq,
  input  logic              retExit,
  output logic              busy,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  dpStrobe_t strobe;

  sram_ctrl_fsm #(
    .CLK_NS(CLK_NS), .T_WP_NS(T_WP_NS), .T_DW_NS(T_DW_NS),
    .T_WHZ_NS(T_WHZ_NS), .T_WC_NS(T_WC_NS), .T_AA_NS(T_AA_NS),
    .T_OE_NS(T_OE_NS), .T_RC_NS(T_RC_NS), .T_REC_NS(T_REC_NS)
  ) ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .retReq(retReq), .retExit(retExit), .reqReady(reqReady),
    .ackValid(ackValid), .busy(busy), .csN(memCsN), .weN(memWeN),
    .oeN(memOeN), .strobe(strobe)
  );

  sram_ctrl_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .memDqIn(memDqIn), .memAddr(memAddr),
    .memDqOut(memDqOut), .memDqOe(memDqOe), .ackRdata(ackRdata)
  );

endmodule

// File: rtl/sram_ctrl_chk.sv
module sram_ctrl_chk #(
  parameter int ADDR_W = 15
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memCsN,
  input logic              memOeN,
  input logic              memWeN,
  input logic              memDqOe,
  input logic              ackValid,
  input logic              busy
);

  a_r2_we_needs_cs: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> !memCsN);

  a_r2_oe_high_in_write: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> memOeN);

  a_r3_addr_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!memCsN && $past(!memCsN)) |-> $stable(memAddr));

  a_r4_drive_in_window: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> (!memWeN && !memCsN));

  a_r4_release_with_we: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> !memDqOe);

  a_r5_read_we_high: assert property (@(posedge clk) disable iff (!rstN)
    !memOeN |-> (memWeN && !memCsN));

  a_r6_ack_pulse: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |=> !ackValid);

  a_r6_ack_pins_idle: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> (memCsN && memWeN && memOeN));

  a_r7_retention_cs_high: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (memCsN && !memDqOe));

endmodule

bind sram_async_ctrl sram_ctrl_chk #(.ADDR_W(ADDR_W)) chk (
  .clk(clk), .rstN(rstN), .memAddr(memAddr), .memCsN(memCsN),
  .memOeN(memOeN), .memWeN(memWeN), .memDqOe(memDqOe),
  .ackValid(ackValid), .busy(busy)
);

// File: tb/sram_async_ctrl_test.sv
module sram_async_ctrl_test;

  localparam int CLK_NS = 10;
  localparam int REC_NS = 1000;

  // Latencies derived from the nanosecond minimums
  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
  localparam int WE_LOW = mx(cdiv(55, CLK_NS), cdiv(30, CLK_NS) + cdiv(30, CLK_NS));
  localparam int WR_LAT = WE_LOW + mx(1, cdiv(70, CLK_NS) - WE_LOW) - 1;
  localparam int RD_WIN = mx(cdiv(70, CLK_NS), cdiv(35, CLK_NS));
  localparam int RD_LAT = RD_WIN + mx(1, cdiv(70, CLK_NS) - RD_WIN) - 1;
  localparam int REC_LAT = cdiv(REC_NS, CLK_NS);

  logic        clk = 0;
  logic        rstN = 0;
  logic        reqValid = 0, reqWrite = 0, retReq = 0, retExit = 0;
  logic [14:0] reqAddr = '0;
  logic [7:0]  reqWdata = '0;
  logic        reqReady, ackValid, busy;
  logic [7:0]  ackRdata;
  logic [14:0] memAddr;
  logic        memCsN, memOeN, memWeN, memDqOe;
  logic [7:0]  memDqOut, memDqIn;

  sram_async_ctrl #(.CLK_NS(CLK_NS), .T_REC_NS(REC_NS)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .ackValid(ackValid), .ackRdata(ackRdata), .retReq(retReq),
    .retExit(retExit), .busy(busy), .memAddr(memAddr), .memCsN(memCsN),
    .memOeN(memOeN), .memWeN(memWeN), .memDqOut(memDqOut),
    .memDqOe(memDqOe), .memDqIn(memDqIn)
  );

  always #(CLK_NS / 2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- cycle-level memory model ----------------
  logic [7:0]  mem [256];
  logic [7:0]  shadow [256];
  int          weLow = 0, drv = 0, firstDrv = 0, rdLow = 0;
  logic [14:0] wAddr, prevAddr;
  logic [7:0]  wData;
  bit          prevCsLow = 0, addrBad = 0, contention = 0, drvGap = 0;
  logic        modelDrive;

  assign modelDrive = !memCsN && !memOeN && memWeN;
  assign memDqIn = modelDrive ? ((rdLow * CLK_NS >= 70) ? mem[memAddr[7:0]] : 8'hEE) : 8'h00;

  always @(negedge clk) begin
    if (rstN) begin
      if (!memCsN && prevCsLow && memAddr != prevAddr) addrBad = 1;
      if (modelDrive && memDqOe) contention = 1;
      if (!memCsN && !memWeN) begin
        if (weLow == 0) wAddr = memAddr;
        weLow++;
        if (memDqOe) begin
          drv++;
          wData = memDqOut;
          if (drv == 1) firstDrv = weLow;
        end else if (drv > 0) drvGap = 1;
      end else if (weLow > 0) begin
        mem[wAddr[7:0]] = wData;
        check(weLow * CLK_NS >= 55, "R2 write pulse width ns", weLow * CLK_NS, 55);
        check(weLow == WE_LOW, "R2 write pulse cycles", weLow, WE_LOW);
        check(drv * CLK_NS >= 30 && !drvGap, "R4 data valid before WE rise ns", drv * CLK_NS, 30);
        check((firstDrv - 1) * CLK_NS >= 30, "R4 turnaround after WE fall ns", (firstDrv - 1) * CLK_NS, 30);
        weLow = 0; drv = 0; firstDrv = 0; drvGap = 0;
      end
      if (modelDrive) rdLow++;
      else rdLow = 0;
      prevCsLow = !memCsN;
      prevAddr  = memAddr;
    end
  end

  // ---------------- access tasks ----------------
  task automatic waitAck(output int n);
    n = 0;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      reqValid = 0;
      if (ackValid) break;
      @(posedge clk);
      n++;
    end
  endtask

  task automatic doWrite(input logic [14:0] a, input logic [7:0] d);
    int n;
    @(negedge clk);
    reqValid = 1; reqWrite = 1; reqAddr = a; reqWdata = d;
    @(posedge clk);
    waitAck(n);
    check(n == WR_LAT, "R6 write ack latency", n, WR_LAT);
    check(memCsN && memWeN && memOeN, "R6 strobes idle at write ack", {memCsN, memWeN, memOeN}, 7);
    shadow[a[7:0]] = d;
    @(negedge clk);
    check(!ackValid, "R6 write ack single cycle", ackValid, 0);
  endtask

  task automatic doRead(input logic [14:0] a);
    int n;
    @(negedge clk);
    reqValid = 1; reqWrite = 0; reqAddr = a;
    @(posedge clk);
    waitAck(n);
    check(n == RD_LAT, "R5 read ack latency", n, RD_LAT);
    check(ackRdata == shadow[a[7:0]], "R5 read data", ackRdata, shadow[a[7:0]]);
    check(memCsN && memOeN, "R6 strobes idle at read ack", {memCsN, memOeN}, 3);
    @(negedge clk);
    check(!ackValid, "R6 read ack single cycle", ackValid, 0);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int n;
    bit csSeen;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i) ^ 8'h5A;
      shadow[i] = 8'(i) ^ 8'h5A;
    end
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check(memCsN && memWeN && memOeN, "R1 strobes high after reset", {memCsN, memWeN, memOeN}, 7);
    check(!memDqOe, "R1 no drive after reset", memDqOe, 0);
    check(!ackValid && !busy, "R1 no ack/busy after reset", {ackValid, busy}, 0);
    check(reqReady, "R1 ready after reset", reqReady, 1);

    // Sweep: address low bytes distinct (1031 = 4*256 + 7)
    for (int i = 0; i < 40; i++) doWrite(15'(i * 1031), 8'(i * 37 + 5));
    for (int i = 39; i >= 0; i--) doRead(15'(i * 1031));
    // Alternating write/read on the same locations
    for (int i = 0; i < 12; i++) begin
      doWrite(15'(i * 2053 + 3), 8'(8'hC3 ^ 8'(i * 11)));
      doRead(15'(i * 2053 + 3));
    end
    doRead(15'h7FF0);  // never written: initial content

    // R9: retention request during a write is ignored
    @(negedge clk);
    reqValid = 1; reqWrite = 1; reqAddr = 15'h1234; reqWdata = 8'h9B;
    @(posedge clk);
    n = 0;
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      reqValid = 0;
      retReq = (n >= 1 && n <= 3);
      if (ackValid) break;
      @(posedge clk);
      n++;
    end
    retReq = 0;
    shadow[8'h34] = 8'h9B;
    check(n == WR_LAT, "R9 write completes with retReq", n, WR_LAT);
    @(negedge clk);
    check(!busy && reqReady, "R9 retReq mid-access ignored", {busy, reqReady}, 1);
    doRead(15'h1234);

    // R7: retention entry, requests held off
    @(negedge clk);
    retReq = 1; reqValid = 1; reqWrite = 0; reqAddr = 15'h1234;
    @(posedge clk);
    @(negedge clk);
    retReq = 0;
    check(busy, "R7 busy in retention", busy, 1);
    check(!reqReady, "R7 not ready in retention", reqReady, 0);
    check(memCsN, "R7 chip select high in retention", memCsN, 1);
    csSeen = 0;
    repeat (20) begin
      @(negedge clk);
      if (!memCsN) csSeen = 1;
    end
    check(!csSeen && busy, "R7 held request not started", csSeen, 0);

    // R8: recovery lockout
    retExit = 1;
    @(posedge clk);
    n = 0;
    for (int k = 0; k < REC_LAT + 20; k++) begin
      @(negedge clk);
      retExit = 0;
      if (reqReady) break;
      if (n == REC_LAT / 2) check(busy && memCsN, "R8 busy during recovery", busy, 1);
      @(posedge clk);
      n++;
    end
    check(n == REC_LAT, "R8 recovery lockout cycles", n, REC_LAT);
    @(posedge clk);
    waitAck(n);
    check(n == RD_LAT, "R8 held read runs after lockout", n, RD_LAT);
    check(ackRdata == 8'h9B, "R8 read data after retention", ackRdata, 8'h9B);
    @(negedge clk);
    check(!busy, "R8 busy clear after lockout", busy, 0);

    check(!addrBad, "R3 address stable while selected", addrBad, 0);
    check(!contention, "R4 no bus contention", contention, 0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_NS * 150000);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule